// File: doc/BRIEF.md
# IQ Demodulator Front End

This block sits at the digital input of one receive channel. An IF signal is sampled at four times its own frequency, so each sample is 90 degrees after the previous one. Over each group of four accepted samples the stream holds the in-phase value, then the quadrature value, then the same two values with the sign reversed. The block sorts this stream into signed I and Q words. It restores the sign of the second half of each group, and it produces one I/Q pair for every two accepted samples, which is half the sample rate.

Each pair then goes through a 2x2 matrix that scales and rotates it. The matrix corrects the fixed gain and phase offset of the channel's analog path. The two coefficients, gain times cosine and gain times sine of the correction angle, come in through a small write port. They are held in a shadow pair and take effect only at the start of a sample group, so a pair is never computed with one old and one new coefficient. A sync input realigns the four-phase sequence to the sampling clock of the converter. Several channels use identical copies of this block.

Top module: `iq_frontend`

## Requirements
- R1: After reset, `iq_vld_o` is low and `i_o` and `q_o` are zero. The active coefficients are cosine term 16384 and sine term 0, so results equal the input pair, sign-extended.
- R2: Accepted samples are handled in a repeating order of four positions. Position 0 is +I and position 1 is +Q; these form one pair. Position 2 is -I and position 3 is -Q; their negations form the next pair. Each accepted position-1 or position-3 sample produces exactly one result.
- R3: When the value -8192 arrives at position 2 or position 3, its negation gives +8191. It does not wrap.
- R4: A cycle with `sync_i` high resets the position to 0. A sample accepted in that same cycle is treated as position 0. A sync with `smp_vld_i` low also resets the position, and any half-formed pair is dropped.
- R5: Cycles with `smp_vld_i` low do not advance the position, and they do not change the pair being formed.
- R6: `iq_vld_o` is high after the third rising edge that follows the edge accepting the second sample of a pair. It is high for that one cycle only.
- R7: The result is Iout = I*C - Q*S and Qout = I*S + Q*C. C and S are signed 16-bit values with 14 fractional bits.
- R8: Each exact result is rounded half upward: add 2^13 to the full-precision sum, then shift right arithmetically by 14.
- R9: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R10: A write with `cfg_sel_i`=0 loads the shadow cosine term, and `cfg_sel_i`=1 loads the shadow sine term. The shadow pair is copied to the active pair when a position-0 sample is accepted. A pair whose first sample was accepted before that copy uses the old coefficients.
- R11: `i_o` and `q_o` hold their values in every cycle where `iq_vld_o` is low. `iq_vld_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 14 | Two's-complement converter sample |
| smp_vld_i | input | 1 | Sample is accepted at this edge |
| sync_i | input | 1 | Resets the four-position sequence to position 0 |
| cfg_we_i | input | 1 | Writes `cfg_data_i` into the selected shadow coefficient |
| cfg_sel_i | input | 1 | 0 selects the cosine term, 1 selects the sine term |
| cfg_data_i | input | 16 | Coefficient value, signed, 14 fractional bits |
| i_o | output | 16 | Calibrated in-phase result |
| q_o | output | 16 | Calibrated quadrature result |
| iq_vld_o | output | 1 | Result strobe |

## Verification
The hardest condition to reach is a coefficient write that lands in the middle of a sample group. The old coefficients must still apply to the pair in progress, and the new ones must apply starting with the next group. The bench writes the cosine term after a position-0 sample and then finishes two pairs. It checks that both pairs still reflect unity gain, and that the pair after the next position-0 sample shows the new scale. Saturation of the sum needs extreme inputs: full-scale negative samples at both positions of a pair with both coefficients at -2.0. The wrap-free negation needs the most negative sample at a negated position. The bench drives both of these cases directly.

// File: rtl/iqfe_pkg.sv
package iqfe_pkg;

    localparam int SMP_W_DEF  = 14;
    localparam int COEF_W_DEF = 16;
    localparam int FRAC_DEF   = 14;
    localparam int OUT_W_DEF  = 16;

    // Position of a sample inside its group of four
    typedef enum logic [1:0] {
        PH_IP = 2'd0,
        PH_QP = 2'd1,
        PH_IN = 2'd2,
        PH_QN = 2'd3
    } phase_e;

    typedef enum logic {
        SEL_COS = 1'b0,
        SEL_SIN = 1'b1
    } coef_sel_e;

    function automatic phase_e phase_step(input phase_e p);
        case (p)
            PH_IP:   return PH_QP;
            PH_QP:   return PH_IN;
            PH_IN:   return PH_QN;
            default: return PH_IP;
        endcase
    endfunction

    function automatic logic phase_is_q(input phase_e p);
        return (p == PH_QP) || (p == PH_QN);
    endfunction

    function automatic logic phase_negates(input phase_e p);
        return (p == PH_IN) || (p == PH_QN);
    endfunction

endpackage

// File: rtl/iqfe_demux.sv
module iqfe_demux
    import iqfe_pkg::*;
#(
    parameter int SMP_W = SMP_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic                    smp_vld_i,
    input  logic                    sync_i,
    output logic                    grp_start_o,
    output logic                    pair_vld_o,
    output logic signed [SMP_W-1:0] pair_i_o,
    output logic signed [SMP_W-1:0] pair_q_o
);

    localparam logic signed [SMP_W-1:0] S_MIN = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic signed [SMP_W-1:0] S_MAX = {1'b0, {(SMP_W-1){1'b1}}};

    phase_e                  ph_q;
    phase_e                  ph_eff;
    logic signed [SMP_W-1:0] neg_smp;
    logic signed [SMP_W-1:0] cond_smp;
    logic signed [SMP_W-1:0] hold_q;

    always_comb begin
        ph_eff      = sync_i ? PH_IP : ph_q;
        neg_smp     = (smp_i == S_MIN) ? S_MAX : -smp_i;
        cond_smp    = phase_negates(ph_eff) ? neg_smp : smp_i;
        grp_start_o = smp_vld_i && (ph_eff == PH_IP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IP;
            hold_q     <= '0;
            pair_vld_o <= 1'b0;
            pair_i_o   <= '0;
            pair_q_o   <= '0;
        end else begin
            pair_vld_o <= 1'b0;
            if (smp_vld_i) begin
                ph_q <= phase_step(ph_eff);
                if (phase_is_q(ph_eff)) begin
                    pair_i_o   <= hold_q;
                    pair_q_o   <= cond_smp;
                    pair_vld_o <= 1'b1;
                end else begin
                    hold_q <= cond_smp;
                end
            end else if (sync_i) begin
                ph_q <= PH_IP;
            end
        end
    end

endmodule

// File: rtl/iqfe_coef.sv
module iqfe_coef
    import iqfe_pkg::*;
#(
    parameter int COEF_W = COEF_W_DEF,
    parameter int FRAC   = FRAC_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  logic                     sel_i,
    input  logic [COEF_W-1:0]        data_i,
    input  logic                     load_i,
    output logic signed [COEF_W-1:0] cos_o,
    output logic signed [COEF_W-1:0] sin_o
);

    localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(longint'(1) << FRAC);

    logic signed [COEF_W-1:0] shd_cos;
    logic signed [COEF_W-1:0] shd_sin;
    coef_sel_e                sel;

    assign sel = coef_sel_e'(sel_i);

    // Shadow pair: software side
    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cos <= UNITY;
            shd_sin <= '0;
        end else if (we_i) begin
            case (sel)
                SEL_COS: shd_cos <= $signed(data_i);
                default: shd_sin <= $signed(data_i);
            endcase
        end
    end

    // Active pair: copied only at a group boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            cos_o <= UNITY;
            sin_o <= '0;
        end else if (load_i) begin
            cos_o <= shd_cos;
            sin_o <= shd_sin;
        end
    end

endmodule

// File: rtl/iqfe_rotate.sv
module iqfe_rotate
    import iqfe_pkg::*;
#(
    parameter int IN_W   = SMP_W_DEF,
    parameter int COEF_W = COEF_W_DEF,
    parameter int FRAC   = FRAC_DEF,
    parameter int OUT_W  = OUT_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld_i,
    input  logic signed [IN_W-1:0]   in_i_i,
    input  logic signed [IN_W-1:0]   in_q_i,
    input  logic signed [COEF_W-1:0] cos_i,
    input  logic signed [COEF_W-1:0] sin_i,
    output logic                     out_vld_o,
    output logic signed [OUT_W-1:0]  out_i_o,
    output logic signed [OUT_W-1:0]  out_q_o
);

    localparam int PROD_W = IN_W + COEF_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int EXT_W  = SUM_W + 1;

    localparam logic signed [EXT_W-1:0] HALF = EXT_W'(longint'(1) << (FRAC-1));
    localparam logic signed [EXT_W-1:0] OMAX = EXT_W'((longint'(1) << (OUT_W-1)) - 1);
    localparam logic signed [EXT_W-1:0] OMIN = -OMAX - EXT_W'(1);

    function automatic logic signed [PROD_W-1:0] smul(
        input logic signed [IN_W-1:0]   a,
        input logic signed [COEF_W-1:0] b
    );
        return $signed({{COEF_W{a[IN_W-1]}}, a}) * $signed({{IN_W{b[COEF_W-1]}}, b});
    endfunction

    function automatic logic signed [SUM_W-1:0] sext(input logic signed [PROD_W-1:0] p);
        return $signed({p[PROD_W-1], p});
    endfunction

    function automatic logic signed [OUT_W-1:0] rnd_sat(input logic signed [SUM_W-1:0] v);
        logic signed [EXT_W-1:0] r;
        r = $signed({v[SUM_W-1], v}) + HALF;
        r = r >>> FRAC;
        if (r > OMAX)      return OMAX[OUT_W-1:0];
        else if (r < OMIN) return OMIN[OUT_W-1:0];
        else               return r[OUT_W-1:0];
    endfunction

    logic                     v1, v2;
    logic signed [PROD_W-1:0] p_ic, p_qs, p_is, p_qc;
    logic signed [SUM_W-1:0]  s_i, s_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            out_vld_o <= 1'b0;
            p_ic      <= '0;
            p_qs      <= '0;
            p_is      <= '0;
            p_qc      <= '0;
            s_i       <= '0;
            s_q       <= '0;
            out_i_o   <= '0;
            out_q_o   <= '0;
        end else begin
            v1        <= in_vld_i;
            v2        <= v1;
            out_vld_o <= v2;
            // Stage 1: four products
            if (in_vld_i) begin
                p_ic <= smul(in_i_i, cos_i);
                p_qs <= smul(in_q_i, sin_i);
                p_is <= smul(in_i_i, sin_i);
                p_qc <= smul(in_q_i, cos_i);
            end
            // Stage 2: matrix sums at full precision
            if (v1) begin
                s_i <= sext(p_ic) - sext(p_qs);
                s_q <= sext(p_is) + sext(p_qc);
            end
            // Stage 3: round and clamp
            if (v2) begin
                out_i_o <= rnd_sat(s_i);
                out_q_o <= rnd_sat(s_q);
            end
        end
    end

endmodule

// File: rtl/iq_frontend.sv
module iq_frontend
    import iqfe_pkg::*;
#(
    parameter int SMP_W  = SMP_W_DEF,
    parameter int COEF_W = COEF_W_DEF,
    parameter int FRAC   = FRAC_DEF,
    parameter int OUT_W  = OUT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic                    smp_vld_i,
    input  logic                    sync_i,
    input  logic                    cfg_we_i,
    input  logic                    cfg_sel_i,
    input  logic [COEF_W-1:0]       cfg_data_i,
    output logic signed [OUT_W-1:0] i_o,
    output logic signed [OUT_W-1:0] q_o,
    output logic                    iq_vld_o
);

    logic                     grp_start;
    logic                     pair_vld;
    logic signed [SMP_W-1:0]  pair_i;
    logic signed [SMP_W-1:0]  pair_q;
    logic signed [COEF_W-1:0] cos_act;
    logic signed [COEF_W-1:0] sin_act;

    iqfe_demux #(.SMP_W(SMP_W)) u_demux (
        .clk         (clk),
        .rst         (rst),
        .smp_i       (smp_i),
        .smp_vld_i   (smp_vld_i),
        .sync_i      (sync_i),
        .grp_start_o (grp_start),
        .pair_vld_o  (pair_vld),
        .pair_i_o    (pair_i),
        .pair_q_o    (pair_q)
    );

    iqfe_coef #(.COEF_W(COEF_W), .FRAC(FRAC)) u_coef (
        .clk    (clk),
        .rst    (rst),
        .we_i   (cfg_we_i),
        .sel_i  (cfg_sel_i),
        .data_i (cfg_data_i),
        .load_i (grp_start),
        .cos_o  (cos_act),
        .sin_o  (sin_act)
    );

    iqfe_rotate #(
        .IN_W   (SMP_W),
        .COEF_W (COEF_W),
        .FRAC   (FRAC),
        .OUT_W  (OUT_W)
    ) u_rot (
        .clk       (clk),
        .rst       (rst),
        .in_vld_i  (pair_vld),
        .in_i_i    (pair_i),
        .in_q_i    (pair_q),
        .cos_i     (cos_act),
        .sin_i     (sin_act),
        .out_vld_o (iq_vld_o),
        .out_i_o   (i_o),
        .out_q_o   (q_o)
    );

endmodule

// File: rtl/iqfe_chk.sv
module iqfe_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld_i,
    input logic             sync_i,
    input logic             pair_vld,
    input logic             iq_vld_o,
    input logic [OUT_W-1:0] i_o,
    input logic [OUT_W-1:0] q_o
);

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        iq_vld_o == $past(pair_vld, 3));

    // R11
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        iq_vld_o |=> !iq_vld_o);

    // R11
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !iq_vld_o |-> ($stable(i_o) && $stable(q_o)));

    // R4
    sync_first_is_i_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_i && smp_vld_i) |=> !pair_vld);

    // R5
    idle_no_pair_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld_i |=> !pair_vld);

endmodule

bind iq_frontend iqfe_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld_i (smp_vld_i),
    .sync_i    (sync_i),
    .pair_vld  (pair_vld),
    .iq_vld_o  (iq_vld_o),
    .i_o       (i_o),
    .q_o       (q_o)
);

// File: tb/sim_iq_frontend.sv
`timescale 1ns/1ps
module sim_iq_frontend;

    logic               clk = 1'b0;
    logic               rst;
    logic signed [13:0] smp_i;
    logic               smp_vld_i;
    logic               sync_i;
    logic               cfg_we_i;
    logic               cfg_sel_i;
    logic [15:0]        cfg_data_i;
    logic signed [15:0] i_o;
    logic signed [15:0] q_o;
    logic               iq_vld_o;

    int checks = 0;
    int errors = 0;
    int mc = 16384;   // bench view of active cosine term
    int ms = 0;       // bench view of active sine term
    int got_i[$], got_q[$], exp_i[$], exp_q[$];

    always #5 clk = ~clk;

    iq_frontend u0 (
        .clk        (clk),
        .rst        (rst),
        .smp_i      (smp_i),
        .smp_vld_i  (smp_vld_i),
        .sync_i     (sync_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_sel_i  (cfg_sel_i),
        .cfg_data_i (cfg_data_i),
        .i_o        (i_o),
        .q_o        (q_o),
        .iq_vld_o   (iq_vld_o)
    );

    always @(negedge clk) begin
        if (!rst && iq_vld_o) begin
            got_i.push_back(int'(i_o));
            got_q.push_back(int'(q_o));
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int nsat(input int x);
        return (x == -8192) ? 8191 : -x;
    endfunction

    function automatic int rs(input longint v);
        longint r;
        r = (v + 64'sd8192) >>> 14;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    task automatic expect_pair(input int i, input int q, input int c, input int s);
        exp_i.push_back(rs(longint'(i) * c - longint'(q) * s));
        exp_q.push_back(rs(longint'(i) * s + longint'(q) * c));
    endtask

    task automatic put(input int x, input logic s);
        smp_i     = 14'(x);
        smp_vld_i = 1'b1;
        sync_i    = s;
        @(negedge clk);
        smp_vld_i = 1'b0;
        sync_i    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic sel, input int val);
        cfg_sel_i  = sel;
        cfg_data_i = 16'(val);
        cfg_we_i   = 1'b1;
        @(negedge clk);
        cfg_we_i   = 1'b0;
    endtask

    // Four samples in sequence, first one with sync; coefficients mc/ms apply
    task automatic group(input int a, input int b, input int c, input int d, input logic s);
        put(a, s); put(b, 1'b0); put(c, 1'b0); put(d, 1'b0);
        expect_pair(a, b, mc, ms);
        expect_pair(nsat(c), nsat(d), mc, ms);
    endtask

    task automatic compare(input string tag);
        idle(6);
        chk(got_i.size() == exp_i.size(), {tag, " result count"}, got_i.size(), exp_i.size());
        for (int k = 0; k < exp_i.size() && k < got_i.size(); k++) begin
            chk(got_i[k] == exp_i[k], $sformatf("%s I[%0d]", tag, k), got_i[k], exp_i[k]);
            chk(got_q[k] == exp_q[k], $sformatf("%s Q[%0d]", tag, k), got_q[k], exp_q[k]);
        end
        got_i.delete(); got_q.delete(); exp_i.delete(); exp_q.delete();
    endtask

    task automatic t_reset();
        chk(iq_vld_o == 1'b0, "R1 valid low after reset", int'(iq_vld_o), 0);
        chk(i_o == 16'sd0, "R1 i_o zero after reset", int'(i_o), 0);
        chk(q_o == 16'sd0, "R1 q_o zero after reset", int'(q_o), 0);
    endtask

    task automatic t_order();
        group(1000, -2000, 300, -400, 1'b1);
        group(-1, 2, -3, 4, 1'b0);
        compare("R1 R2 unity order");
    endtask

    task automatic t_negsat();
        group(-8192, -8192, -8192, -8192, 1'b1);
        group(8191, -8192, 8191, 0, 1'b0);
        compare("R3 negate most negative");
    endtask

    task automatic t_sync();
        put(111, 1'b1); put(222, 1'b0); put(333, 1'b0);
        put(444, 1'b1); put(555, 1'b0);
        expect_pair(111, 222, mc, ms);
        expect_pair(444, 555, mc, ms);
        put(10, 1'b0); put(20, 1'b0); put(30, 1'b0);
        expect_pair(-10, -20, mc, ms);
        sync_i = 1'b1; @(negedge clk); sync_i = 1'b0;
        put(40, 1'b0); put(50, 1'b0);
        expect_pair(40, 50, mc, ms);
        compare("R4 sync realign");
    endtask

    task automatic t_gaps();
        put(600, 1'b1); idle(3);
        put(700, 1'b0); idle(2);
        put(800, 1'b0); idle(1);
        put(900, 1'b0); idle(4);
        put(-50, 1'b0); idle(2);
        put(60, 1'b0);
        expect_pair(600, 700, mc, ms);
        expect_pair(-800, -900, mc, ms);
        expect_pair(-50, 60, mc, ms);
        compare("R5 idle gaps");
    endtask

    task automatic t_latency();
        logic signed [15:0] hi, hq;
        put(5, 1'b1);
        smp_i = 14'sd7; smp_vld_i = 1'b1;
        @(negedge clk);
        smp_vld_i = 1'b0;
        chk(iq_vld_o == 1'b0, "R6 not valid after accept edge", int'(iq_vld_o), 0);
        @(negedge clk);
        chk(iq_vld_o == 1'b0, "R6 not valid after edge+1", int'(iq_vld_o), 0);
        @(negedge clk);
        chk(iq_vld_o == 1'b0, "R6 not valid after edge+2", int'(iq_vld_o), 0);
        @(negedge clk);
        chk(iq_vld_o == 1'b1, "R6 valid after edge+3", int'(iq_vld_o), 1);
        hi = i_o; hq = q_o;
        @(negedge clk);
        chk(iq_vld_o == 1'b0, "R11 valid single cycle", int'(iq_vld_o), 0);
        idle(3);
        chk(i_o == hi, "R11 i_o held while idle", int'(i_o), int'(hi));
        chk(q_o == hq, "R11 q_o held while idle", int'(q_o), int'(hq));
        expect_pair(5, 7, mc, ms);
        compare("R6 latency pair");
    endtask

    task automatic t_coef_update();
        put(100, 1'b1);
        cfg(1'b0, 8192);              // mid-group write of cosine term (0.5)
        put(200, 1'b0);
        put(-300, 1'b0); put(-400, 1'b0);
        expect_pair(100, 200, 16384, 0);
        expect_pair(300, 400, 16384, 0);
        put(1000, 1'b0); put(2000, 1'b0);
        expect_pair(1000, 2000, 8192, 0);
        cfg(1'b1, 16384);             // sine term 1.0, takes effect next group
        put(-10, 1'b0); put(-20, 1'b0);
        expect_pair(-(-10), -(-20), 8192, 0);
        put(10, 1'b0); put(20, 1'b0);
        expect_pair(10, 20, 8192, 16384);
        mc = 8192; ms = 16384;
        compare("R10 coefficient boundary");
    endtask

    task automatic t_rotate();
        cfg(1'b0, 13000); cfg(1'b1, -7000);
        mc = 13000; ms = -7000;
        group(4000, -1500, 2222, 7777, 1'b1);
        group(-8192, 8191, 123, -321, 1'b0);
        compare("R7 rotation");
        cfg(1'b0, 8192); cfg(1'b1, 0);
        mc = 8192; ms = 0;
        group(101, -101, -101, 101, 1'b1);   // 50.5 -> 51, -50.5 -> -50
        group(3, -3, 1, -1, 1'b0);
        compare("R8 round half up");
    endtask

    task automatic t_sat();
        cfg(1'b0, -32768); cfg(1'b1, -32768);
        mc = -32768; ms = -32768;
        group(-8192, -8192, 8191, 8191, 1'b1);
        compare("R9 clamp positive");
        cfg(1'b0, 32767); cfg(1'b1, 32767);
        mc = 32767; ms = 32767;
        group(8191, 8191, -8192, 8191, 1'b1);
        compare("R9 large sums");
        chk(exp_i.size() == 0, "R9 queues drained", exp_i.size(), 0);
    endtask

    initial begin
        rst = 1'b1; smp_i = '0; smp_vld_i = 1'b0; sync_i = 1'b0;
        cfg_we_i = 1'b0; cfg_sel_i = 1'b0; cfg_data_i = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_order();
        t_negsat();
        t_sync();
        t_gaps();
        t_latency();
        t_coef_update();
        t_rotate();
        t_sat();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R6 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule